// File: doc/BRIEF.md
# Compressed instruction expander

This block turns one 16-bit compressed RISC-V instruction into the 32-bit base instruction that does the same thing. It also raises an illegal flag when the halfword is not a valid RV32 compressed integer instruction. The expander has no clock and no state. A fetch or decode stage places it in front of a decoder that only understands 32-bit words, so that decoder never sees the compressed forms.

Inside, a control half classifies the halfword into one instruction kind and passes that kind to a datapath half as a small strobe struct. The datapath reassembles the scrambled immediate of each format, widens the three-bit register fields, and packs the fields into the base encoding. An illegal halfword always produces an all-zero word. Floating-point compressed forms, push/pop-style stack forms and the reserved slots are all illegal.

Top module: `rvc_expander`

## Requirements
- R1: A halfword whose bits 1:0 are 11 is not compressed. It raises illegalOut and drives wordOut to zero.
- R2: Whenever illegalOut is high, wordOut is zero. Whenever it is low, wordOut[1:0] is 11.
- R3: The three-bit register fields at bits 9:7 and 4:2 name registers x8 to x15 (field value plus 8) in the expanded word.
- R4: Quadrant 00, funct3 000 expands to addi rd', x2, imm. The immediate takes bits 12:11 at 5:4, bits 10:7 at 9:6, bit 6 at 2 and bit 5 at 3. A zero immediate, which includes the all-zero halfword, is illegal.
- R5: Quadrant 00, funct3 010 and 110 expand to lw rd', off(rs1') and sw rs2', off(rs1'). The offset takes bit 6 at 2, bits 12:10 at 5:3 and bit 5 at 6.
- R6: Quadrant 01, funct3 001 expands to jal x1 and funct3 101 to jal x0. The offset is signed by bit 12 (offset 11) and takes bit 11 at 4, 10:9 at 9:8, 8 at 10, 7 at 6, 6 at 7, 5:3 at 3:1 and 2 at 5.
- R7: Quadrant 01, funct3 110 and 111 expand to beq and bne of rs1' against x0. The offset is signed by bit 12 (offset 8) and takes 11:10 at 4:3, 6:5 at 7:6, 4:3 at 2:1 and 2 at 5.
- R8: Quadrant 01, funct3 011 with rd = x2 is addi x2, x2, imm. That immediate is signed by bit 12 (offset 9) and takes 6 at 4, 5 at 6, 4:3 at 8:7 and 2 at 5. With any other rd it is lui rd with a sign-extended {12, 6:2} upper immediate. A zero immediate is illegal in both cases.
- R9: Quadrant 01, funct3 100 selects by bits 11:10: srli (00), srai (01), andi (10) on rd'. For 11, bits 6:5 select sub, xor, or, and with rs2'. A shift amount with bit 12 set, and the 11 group with bit 12 set, are illegal.
- R10: Quadrant 10, funct3 100 with bit 12 clear is jalr x0, 0(rs1) when rs2 = 0 (illegal if rs1 = 0), and otherwise add rd, x0, rs2. With bit 12 set it is ebreak when rs1 = rs2 = 0, jalr x1, 0(rs1) when only rs2 = 0, and otherwise add rd, rd, rs2.
- R11: Quadrant 10, funct3 010 is lw rd, off(x2), with bit 12 at 5, 6:4 at 4:2 and 3:2 at 7:6; rd = 0 is illegal. Funct3 110 is sw rs2, off(x2), with 12:9 at 5:2 and 8:7 at 7:6.
- R12: Quadrant 01, funct3 000 is addi rd, rd, imm and funct3 010 is addi rd, x0, imm, each with the signed six-bit {12, 6:2} immediate. Quadrant 10, funct3 000 is slli rd, rd, shamt, and is illegal when bit 12 is set.
- R13: Every other encoding is illegal. This covers quadrant 00 funct3 001, 011, 100, 101, 111 and quadrant 10 funct3 001, 011, 101, 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| halfIn | input | 16 | Compressed instruction halfword |
| wordOut | output | 32 | Equivalent 32-bit instruction, zero when illegal |
| illegalOut | output | 1 | High when the halfword has no legal expansion |

## Verification
The bench sweeps all 65536 halfwords against an arithmetic model of each format. It also runs a set of hand-encoded pairs. The sweep matters because the sign bit, the zero-immediate rules and the bit-12 splits all sit on single bits. Scrambling one immediate bit moves one jump or branch target. Losing a bit-12 check turns an RV64-only form into a wrong legal word. Misreading the rs2/rs1 zero tests in the jump/add slot turns a breakpoint or a return into an add. The directed pairs hit each of those boundaries by name: the all-zero halfword, jr x0, lwsp x0, a zero lui immediate, the most negative branch offset and a jump to -2.

// File: rtl/rvc_expander_pkg.sv
package rvc_expander_pkg;
  parameter int HALF_W = 16;
  parameter int WORD_W = 32;
  parameter int REG_W  = 5;
  parameter int OPC_W  = 7;

  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [WORD_W-1:0] WORD_EBREAK = 32'h0010_0073;

  typedef enum logic [4:0] {
    K_ILL, K_ADDI4SPN, K_LW, K_SW, K_ADDI, K_JAL, K_LI, K_ADDI16SP, K_LUI,
    K_SRLI, K_SRAI, K_ANDI, K_SUB, K_XOR, K_OR, K_AND, K_J, K_BEQZ, K_BNEZ,
    K_SLLI, K_MV, K_JR, K_ADD, K_JALR, K_EBREAK, K_LWSP, K_SWSP
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  illegal;
  } strobe_t;

  function automatic logic [WORD_W-1:0] encI(logic [11:0] imm, logic [REG_W-1:0] rs1,
      logic [2:0] f3, logic [REG_W-1:0] rd, logic [OPC_W-1:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [WORD_W-1:0] encR(logic [6:0] f7, logic [REG_W-1:0] rs2,
      logic [REG_W-1:0] rs1, logic [2:0] f3, logic [REG_W-1:0] rd, logic [OPC_W-1:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [WORD_W-1:0] encS(logic [11:0] imm, logic [REG_W-1:0] rs2,
      logic [REG_W-1:0] rs1, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [WORD_W-1:0] encB(logic [12:0] imm, logic [REG_W-1:0] rs1,
      logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [WORD_W-1:0] encJ(logic [20:0] imm, logic [REG_W-1:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction
endpackage

// File: rtl/rvc_expander_ctrl.sv
module rvc_expander_ctrl
  import rvc_expander_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  output strobe_t           strobes
);
  logic [1:0]       quad;
  logic [2:0]       func;
  logic [REG_W-1:0] rdFull, rs2Full;
  logic             sixZero;
  kind_e            kind;

  assign quad    = halfIn[1:0];
  assign func    = halfIn[15:13];
  assign rdFull  = halfIn[11:7];
  assign rs2Full = halfIn[6:2];
  assign sixZero = (halfIn[12] == 1'b0) && (rs2Full == '0);

  always_comb begin
    kind = K_ILL;
    unique case (quad)
      2'b00: begin
        unique case (func)
          3'b000:  kind = (halfIn[12:5] == '0) ? K_ILL : K_ADDI4SPN;
          3'b010:  kind = K_LW;
          3'b110:  kind = K_SW;
          default: kind = K_ILL;
        endcase
      end
      2'b01: begin
        unique case (func)
          3'b000: kind = K_ADDI;
          3'b001: kind = K_JAL;
          3'b010: kind = K_LI;
          3'b011: begin
            if (sixZero)               kind = K_ILL;
            else if (rdFull == 5'd2)   kind = K_ADDI16SP;
            else                       kind = K_LUI;
          end
          3'b100: begin
            unique case (halfIn[11:10])
              2'b00: kind = halfIn[12] ? K_ILL : K_SRLI;
              2'b01: kind = halfIn[12] ? K_ILL : K_SRAI;
              2'b10: kind = K_ANDI;
              default: begin
                if (halfIn[12]) kind = K_ILL;
                else begin
                  unique case (halfIn[6:5])
                    2'b00:   kind = K_SUB;
                    2'b01:   kind = K_XOR;
                    2'b10:   kind = K_OR;
                    default: kind = K_AND;
                  endcase
                end
              end
            endcase
          end
          3'b101:  kind = K_J;
          3'b110:  kind = K_BEQZ;
          default: kind = K_BNEZ;
        endcase
      end
      2'b10: begin
        unique case (func)
          3'b000: kind = halfIn[12] ? K_ILL : K_SLLI;
          3'b010: kind = (rdFull == '0) ? K_ILL : K_LWSP;
          3'b100: begin
            if (!halfIn[12]) begin
              if (rs2Full != '0)       kind = K_MV;
              else if (rdFull != '0)   kind = K_JR;
              else                     kind = K_ILL;
            end else begin
              if (rs2Full != '0)       kind = K_ADD;
              else if (rdFull != '0)   kind = K_JALR;
              else                     kind = K_EBREAK;
            end
          end
          3'b110:  kind = K_SWSP;
          default: kind = K_ILL;
        endcase
      end
      default: kind = K_ILL;
    endcase
  end

  assign strobes.kind    = kind;
  assign strobes.illegal = (kind == K_ILL);

  always_comb begin
    if (!$isunknown(halfIn)) begin
      AST_QUAD3_ILLEGAL: assert (quad != 2'b11 || strobes.illegal);       // R1
      AST_ZERO_HALF: assert (halfIn != '0 || strobes.illegal);            // R4
    end
  end
endmodule

// File: rtl/rvc_expander_dp.sv
module rvc_expander_dp
  import rvc_expander_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  input  strobe_t           strobes,
  output logic [WORD_W-1:0] wordOut
);
  logic [REG_W-1:0] rdFull, rs2Full, regA, regB;
  logic [11:0] ciImm, memOff, a4Imm, spImm, lwspOff, swspOff;
  logic [19:0] luiImm;
  logic [20:0] cjImm;
  logic [12:0] cbImm;
  logic [4:0]  shamt;
  logic        h12;

  assign h12     = halfIn[12];
  assign rdFull  = halfIn[11:7];
  assign rs2Full = halfIn[6:2];
  assign regA    = {2'b01, halfIn[9:7]};
  assign regB    = {2'b01, halfIn[4:2]};
  assign shamt   = halfIn[6:2];

  assign ciImm   = {{6{h12}}, h12, halfIn[6:2]};
  assign luiImm  = {{14{h12}}, h12, halfIn[6:2]};
  assign memOff  = {5'd0, halfIn[5], halfIn[12:10], halfIn[6], 2'b00};
  assign a4Imm   = {2'd0, halfIn[10:7], halfIn[12:11], halfIn[5], halfIn[6], 2'b00};
  assign spImm   = {{2{h12}}, h12, halfIn[4:3], halfIn[5], halfIn[2], halfIn[6], 4'd0};
  assign lwspOff = {4'd0, halfIn[3:2], h12, halfIn[6:4], 2'b00};
  assign swspOff = {4'd0, halfIn[8:7], halfIn[12:9], 2'b00};
  assign cjImm   = {{9{h12}}, h12, halfIn[8], halfIn[10:9], halfIn[6], halfIn[7],
                    halfIn[2], halfIn[11], halfIn[5:3], 1'b0};
  assign cbImm   = {{4{h12}}, h12, halfIn[6:5], halfIn[2], halfIn[11:10], halfIn[4:3], 1'b0};

  always_comb begin
    wordOut = '0;
    unique case (strobes.kind)
      K_ADDI4SPN: wordOut = encI(a4Imm, 5'd2, 3'b000, regB, OPC_OPIMM);
      K_LW:       wordOut = encI(memOff, regA, 3'b010, regB, OPC_LOAD);
      K_SW:       wordOut = encS(memOff, regB, regA, 3'b010);
      K_ADDI:     wordOut = encI(ciImm, rdFull, 3'b000, rdFull, OPC_OPIMM);
      K_JAL:      wordOut = encJ(cjImm, 5'd1);
      K_J:        wordOut = encJ(cjImm, 5'd0);
      K_LI:       wordOut = encI(ciImm, 5'd0, 3'b000, rdFull, OPC_OPIMM);
      K_ADDI16SP: wordOut = encI(spImm, 5'd2, 3'b000, 5'd2, OPC_OPIMM);
      K_LUI:      wordOut = {luiImm, rdFull, OPC_LUI};
      K_SRLI:     wordOut = encR(7'h00, shamt, regA, 3'b101, regA, OPC_OPIMM);
      K_SRAI:     wordOut = encR(7'h20, shamt, regA, 3'b101, regA, OPC_OPIMM);
      K_ANDI:     wordOut = encI(ciImm, regA, 3'b111, regA, OPC_OPIMM);
      K_SUB:      wordOut = encR(7'h20, regB, regA, 3'b000, regA, OPC_OP);
      K_XOR:      wordOut = encR(7'h00, regB, regA, 3'b100, regA, OPC_OP);
      K_OR:       wordOut = encR(7'h00, regB, regA, 3'b110, regA, OPC_OP);
      K_AND:      wordOut = encR(7'h00, regB, regA, 3'b111, regA, OPC_OP);
      K_BEQZ:     wordOut = encB(cbImm, regA, 3'b000);
      K_BNEZ:     wordOut = encB(cbImm, regA, 3'b001);
      K_SLLI:     wordOut = encR(7'h00, shamt, rdFull, 3'b001, rdFull, OPC_OPIMM);
      K_MV:       wordOut = encR(7'h00, rs2Full, 5'd0, 3'b000, rdFull, OPC_OP);
      K_ADD:      wordOut = encR(7'h00, rs2Full, rdFull, 3'b000, rdFull, OPC_OP);
      K_JR:       wordOut = encI(12'd0, rdFull, 3'b000, 5'd0, OPC_JALR);
      K_JALR:     wordOut = encI(12'd0, rdFull, 3'b000, 5'd1, OPC_JALR);
      K_EBREAK:   wordOut = WORD_EBREAK;
      K_LWSP:     wordOut = encI(lwspOff, 5'd2, 3'b010, rdFull, OPC_LOAD);
      K_SWSP:     wordOut = encS(swspOff, rs2Full, 5'd2, 3'b010);
      default:    wordOut = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(halfIn)) begin
      AST_LINK_X1: assert (!(strobes.kind == K_JAL || strobes.kind == K_JALR)
                           || wordOut[11:7] == 5'd1);                       // R6
      AST_COMPACT_RANGE: assert (strobes.kind != K_LW
                                 || (wordOut[19:15] >= 5'd8 && wordOut[19:15] <= 5'd15)); // R3
    end
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_expander_pkg::*;
(
  input  logic [15:0] halfIn,
  output logic [31:0] wordOut,
  output logic        illegalOut
);
  strobe_t strobes;

  rvc_expander_ctrl u_ctrl (
    .halfIn  (halfIn),
    .strobes (strobes)
  );

  rvc_expander_dp u_dp (
    .halfIn  (halfIn),
    .strobes (strobes),
    .wordOut (wordOut)
  );

  assign illegalOut = strobes.illegal;

  always_comb begin
    if (!$isunknown(halfIn)) begin
      AST_ILLEGAL_EMPTY: assert (!illegalOut || wordOut == '0);           // R2
      AST_LEGAL_SIZE: assert (illegalOut || wordOut[1:0] == 2'b11);       // R2
    end
  end
endmodule

// File: tb/rvc_expander_bench.sv
module rvc_expander_bench;
  logic        clk = 1'b0;
  logic [15:0] halfIn = 16'h0000;
  logic [31:0] wordOut;
  logic        illegalOut;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rvc_expander u_rvc_expander (
    .halfIn     (halfIn),
    .wordOut    (wordOut),
    .illegalOut (illegalOut)
  );

  function automatic logic [31:0] mkI(int imm, int rs1, int f3, int rd, int op);
    logic [31:0] v = imm; logic [31:0] a = rs1; logic [31:0] f = f3;
    logic [31:0] d = rd; logic [31:0] o = op;
    return {v[11:0], a[4:0], f[2:0], d[4:0], o[6:0]};
  endfunction

  function automatic logic [31:0] mkR(int f7, int rs2, int rs1, int f3, int rd, int op);
    logic [31:0] s = f7; logic [31:0] b = rs2;
    return {s[6:0], b[4:0], 20'd0} | mkI(0, rs1, f3, rd, op);
  endfunction

  function automatic logic [31:0] mkS(int imm, int rs2, int rs1);
    logic [31:0] v = imm; logic [31:0] b = rs2; logic [31:0] a = rs1;
    return {v[11:5], b[4:0], a[4:0], 3'b010, v[4:0], 7'h23};
  endfunction

  function automatic logic [31:0] mkB(int imm, int rs1, int f3);
    logic [31:0] v = imm; logic [31:0] a = rs1; logic [31:0] f = f3;
    return {v[12], v[10:5], 5'd0, a[4:0], f[2:0], v[4:1], v[11], 7'h63};
  endfunction

  function automatic logic [31:0] mkJ(int imm, int rd);
    logic [31:0] v = imm; logic [31:0] d = rd;
    return {v[20], v[10:1], v[11], v[19:12], d[4:0], 7'h6F};
  endfunction

  function automatic void model(input logic [15:0] h, output logic [31:0] w, output bit bad);
    int q = int'(h[1:0]);
    int f = int'(h[15:13]);
    int rd = int'(h[11:7]);
    int r2 = int'(h[6:2]);
    int ra = 8 + int'(h[9:7]);
    int rb = 8 + int'(h[4:2]);
    int ci = int'(h[6:2]) - 32 * int'(h[12]);
    int cj = -2048 * int'(h[12]) + 16 * int'(h[11]) + 256 * int'(h[10:9]) + 1024 * int'(h[8])
             + 64 * int'(h[7]) + 128 * int'(h[6]) + 2 * int'(h[5:3]) + 32 * int'(h[2]);
    int cb = -256 * int'(h[12]) + 8 * int'(h[11:10]) + 64 * int'(h[6:5]) + 2 * int'(h[4:3])
             + 32 * int'(h[2]);
    int mo = 4 * int'(h[6]) + 8 * int'(h[12:10]) + 64 * int'(h[5]);
    int u4 = 16 * int'(h[12:11]) + 64 * int'(h[10:7]) + 4 * int'(h[6]) + 8 * int'(h[5]);
    int sp = -512 * int'(h[12]) + 16 * int'(h[6]) + 64 * int'(h[5]) + 128 * int'(h[4:3])
             + 32 * int'(h[2]);
    logic [31:0] up;
    bad = 0;
    w = 32'd0;
    if (q == 3) bad = 1;
    else if (q == 0) begin
      if (f == 0) begin
        if (u4 == 0) bad = 1; else w = mkI(u4, 2, 0, rb, 'h13);
      end else if (f == 2) w = mkI(mo, ra, 2, rb, 'h03);
      else if (f == 6) w = mkS(mo, rb, ra);
      else bad = 1;
    end else if (q == 1) begin
      case (f)
        0: w = mkI(ci, rd, 0, rd, 'h13);
        1: w = mkJ(cj, 1);
        2: w = mkI(ci, 0, 0, rd, 'h13);
        3: begin
          if (rd == 2) begin
            if (sp == 0) bad = 1; else w = mkI(sp, 2, 0, 2, 'h13);
          end else if (ci == 0) bad = 1;
          else begin
            up = ci * 4096;
            w = {up[31:12], rd[4:0], 7'h37};
          end
        end
        4: begin
          case (int'(h[11:10]))
            0: if (h[12]) bad = 1; else w = mkR(0, r2, ra, 5, ra, 'h13);
            1: if (h[12]) bad = 1; else w = mkR(32, r2, ra, 5, ra, 'h13);
            2: w = mkI(ci, ra, 7, ra, 'h13);
            default: begin
              if (h[12]) bad = 1;
              else case (int'(h[6:5]))
                0: w = mkR(32, rb, ra, 0, ra, 'h33);
                1: w = mkR(0, rb, ra, 4, ra, 'h33);
                2: w = mkR(0, rb, ra, 6, ra, 'h33);
                default: w = mkR(0, rb, ra, 7, ra, 'h33);
              endcase
            end
          endcase
        end
        5: w = mkJ(cj, 0);
        6: w = mkB(cb, ra, 0);
        default: w = mkB(cb, ra, 1);
      endcase
    end else begin
      case (f)
        0: if (h[12]) bad = 1; else w = mkR(0, r2, rd, 1, rd, 'h13);
        2: if (rd == 0) bad = 1;
           else w = mkI(32 * int'(h[12]) + 4 * int'(h[6:4]) + 64 * int'(h[3:2]), 2, 2, rd, 'h03);
        4: begin
          if (!h[12]) begin
            if (r2 != 0) w = mkR(0, r2, 0, 0, rd, 'h33);
            else if (rd != 0) w = mkI(0, rd, 0, 0, 'h67);
            else bad = 1;
          end else begin
            if (r2 != 0) w = mkR(0, r2, rd, 0, rd, 'h33);
            else if (rd != 0) w = mkI(0, rd, 0, 1, 'h67);
            else w = 32'h0010_0073;
          end
        end
        6: w = mkS(4 * int'(h[12:9]) + 64 * int'(h[8:7]), r2, 2);
        default: bad = 1;
      endcase
    end
  endfunction

  task automatic apply(input logic [15:0] h);
    @(posedge clk);
    halfIn = h;
    @(negedge clk);
  endtask

  task automatic expectPair(input string tag, input logic [15:0] h,
                            input logic [31:0] expW, input bit expBad);
    apply(h);
    checks++;
    if (wordOut !== expW || illegalOut !== expBad) begin
      errors++;
      $display("FAIL %s half=%04h actual word=%08h ill=%0b expected word=%08h ill=%0b",
               tag, h, wordOut, illegalOut, expW, expBad);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] mw;
    bit mb;
    expectPair("R1 quadrant 11", 16'h0003, 32'h0, 1'b1);
    expectPair("R1 all ones", 16'hFFFF, 32'h0, 1'b1);
    expectPair("R4 zero halfword", 16'h0000, 32'h0, 1'b1);
    expectPair("R4 R3 addi4spn", 16'h0040, 32'h0041_0413, 1'b0);
    expectPair("R5 R3 lw", 16'h4144, 32'h0045_2483, 1'b0);
    expectPair("R6 j minus two", 16'hBFFD, 32'hFFFF_F06F, 1'b0);
    expectPair("R6 jal link", 16'h2021, 32'h0080_00EF, 1'b0);
    expectPair("R7 R3 beqz", 16'hC019, 32'h0004_0363, 1'b0);
    expectPair("R7 bnez min offset", 16'hF081, 32'hF004_90E3, 1'b0);
    expectPair("R8 addi16sp", 16'h717D, 32'hFF01_0113, 1'b0);
    expectPair("R8 lui", 16'h6285, 32'h0000_12B7, 1'b0);
    expectPair("R8 lui zero imm", 16'h6281, 32'h0, 1'b1);
    expectPair("R9 srai", 16'h8411, 32'h4044_5413, 1'b0);
    expectPair("R9 sub", 16'h8C05, 32'h4094_0433, 1'b0);
    expectPair("R9 shamt bit12", 16'h9001, 32'h0, 1'b1);
    expectPair("R10 jr", 16'h8082, 32'h0000_8067, 1'b0);
    expectPair("R10 ebreak", 16'h9002, 32'h0010_0073, 1'b0);
    expectPair("R10 jalr", 16'h9282, 32'h0002_80E7, 1'b0);
    expectPair("R10 mv", 16'h852E, 32'h00B0_0533, 1'b0);
    expectPair("R10 add", 16'h952E, 32'h00B5_0533, 1'b0);
    expectPair("R10 jr x0", 16'h8002, 32'h0, 1'b1);
    expectPair("R11 lwsp", 16'h4412, 32'h0041_2403, 1'b0);
    expectPair("R11 lwsp x0", 16'h4012, 32'h0, 1'b1);
    expectPair("R11 swsp", 16'hC426, 32'h0091_2423, 1'b0);
    expectPair("R12 slli", 16'h028E, 32'h0032_9293, 1'b0);
    expectPair("R12 li", 16'h53FD, 32'hFFF0_0393, 1'b0);
    expectPair("R13 fp load slot", 16'h2000, 32'h0, 1'b1);
    expectPair("R13 stack slot", 16'hA002, 32'h0, 1'b1);
    for (int i = 0; i < 65536; i++) begin
      model(i[15:0], mw, mb);
      expectPair("R2 R13 sweep", i[15:0], mw, mb);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule